// File: doc/BRIEF.md
# Page Write Buffer and Timed Write Engine

This block sits behind a two-wire serial memory front end. It gathers the bytes of a write command into a page-sized latch and hands the whole page to the memory array as one request. The front end supplies decoded events: the START and STOP conditions, the block-select bits of the control byte, the word-address byte, and a strobe for each received data byte. The block keeps the 11-bit address pointer. Each data byte advances only the in-page offset of that pointer, so a long or unaligned write wraps around inside its own page.

Nothing is programmed until STOP arrives. On STOP, the block issues one request that carries the page index, a byte-enable mask for the bytes actually received, and the page data. It then holds a busy flag for a fixed number of clocks, which models the self-timed programming cycle. While busy is high the front end does not acknowledge, and this block ignores every strobe. A write-protect input suppresses the request entirely. A START that arrives before STOP drops the collected bytes but keeps the pointer, so a random-read set-up works as expected.

Top module: `pw_engine`

## Requirements
- R1: After reset, `busy`, `wr_req` and `ptr` are all zero.
- R2: When `busy` is low, an `addr_vld` strobe loads `ptr` with `blk_sel` as the upper 3 bits and `addr_byte` as the lower 8 bits. It also discards any bytes collected earlier.
- R3: When `busy` is low, a `data_vld` strobe stores `data_byte` in latch slot `ptr[3:0]` and increments `ptr[3:0]` modulo 16. `ptr[10:4]` stays unchanged, so offset 15 is followed by offset 0 of the same page.
- R4: If more than 16 bytes arrive before STOP, a later byte replaces the earlier byte in the same slot. The commit carries the newest value for each slot.
- R5: A STOP with at least one collected byte, while `wp_i` is low and `busy` is low, raises `wr_req` for exactly one cycle, in the cycle after the STOP. During that cycle `wr_page` equals `ptr[10:4]`, bit i of `wr_be` is set only if offset i was written, and byte i of `wr_data` sits at bits 8i+7:8i.
- R6: A STOP with no collected byte causes neither a request nor busy.
- R7: `busy` rises in the cycle after an accepted STOP and stays high for exactly `WRITE_CYCLES` cycles. While `busy` is high, the address, data, START and STOP strobes have no effect: `ptr` holds and no further request is made.
- R8: A STOP while `wp_i` is high causes no request and no busy. It also discards the collected bytes, so a following STOP with `wp_i` low commits nothing.
- R9: A START before STOP discards the collected bytes and leaves `ptr` unchanged.
- R10: A data strobe in the same cycle as STOP is stored and included in that commit.
- R11: After a commit the collected-byte marks are empty, so the next write's mask holds only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_evt | input | 1 | START condition seen on the bus |
| stop_evt | input | 1 | STOP condition seen on the bus |
| wp_i | input | 1 | Write-protect level |
| blk_sel | input | 3 | Block-select bits from the control byte |
| addr_vld | input | 1 | Word-address byte strobe |
| addr_byte | input | 8 | Word-address byte |
| data_vld | input | 1 | Data byte strobe |
| data_byte | input | 8 | Data byte |
| wr_req | output | 1 | One-cycle page write request to the array |
| wr_page | output | 7 | Page index of the request |
| wr_be | output | 16 | Byte-enable mask of the request |
| wr_data | output | 128 | Page data of the request |
| busy | output | 1 | Programming cycle in progress |
| ptr | output | 11 | Current address pointer |

## Verification
Two functions can coincide in one cycle: the storing of a data byte and the STOP that triggers the commit. The bench drives `data_vld` and `stop_evt` in the same cycle and expects the request one cycle later, with that byte's enable bit and data included. A behavioural reference model, built on a plain byte array and integer counters, predicts the pointer, busy, request, mask and enabled data bytes. These predictions are compared in every cycle, including while strobes are driven during busy to confirm they are ignored.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int unsigned PW_ADDR_W     = 11;
    localparam int unsigned PW_BLK_W      = 3;
    localparam int unsigned PW_PAGE_BYTES = 16;
    // about 10 ms at 125 MHz
    localparam int unsigned PW_WRITE_CYC  = 1250000;
endpackage

// File: rtl/pw_latch.sv
module pw_latch #(
    parameter int unsigned NBYTES = 16,
    localparam int unsigned OFS_W = $clog2(NBYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  we,
    input  logic [OFS_W-1:0]      ofs,
    input  logic [7:0]            din,
    output logic [NBYTES-1:0]     valid_o,
    output logic [NBYTES*8-1:0]   data_o
);
    logic [NBYTES-1:0] vld_d, vld_q;

    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        logic [7:0] byte_d, byte_q;
        logic       hit;

        always_comb begin
            hit      = we && (ofs == OFS_W'(g));
            byte_d   = hit ? din : byte_q;
            vld_d[g] = clr ? 1'b0 : (hit ? 1'b1 : vld_q[g]);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) byte_q <= '0;
            else        byte_q <= byte_d;
        end

        assign data_o[g*8 +: 8] = byte_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    assign valid_o = vld_q;

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (valid_o == '0)); // R11
endmodule

// File: rtl/pw_timer.sv
module pw_timer #(
    parameter int unsigned CYCLES = 1250000,
    localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (launch) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CNT_W'(CYCLES - 1);
        end else if (t_q.busy) begin
            if (t_q.cnt == '0) t_d.busy = 1'b0;
            else               t_d.cnt  = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign busy = t_q.busy;

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (t_q.cnt < CNT_W'(CYCLES))); // R7
endmodule

// File: rtl/pw_engine.sv
module pw_engine
    import pw_pkg::*;
#(
    parameter int unsigned ADDR_W       = PW_ADDR_W,
    parameter int unsigned BLK_W        = PW_BLK_W,
    parameter int unsigned PAGE_BYTES   = PW_PAGE_BYTES,
    parameter int unsigned WRITE_CYCLES = PW_WRITE_CYC
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start_evt,
    input  logic                                   stop_evt,
    input  logic                                   wp_i,
    input  logic [BLK_W-1:0]                       blk_sel,
    input  logic                                   addr_vld,
    input  logic [ADDR_W-BLK_W-1:0]                addr_byte,
    input  logic                                   data_vld,
    input  logic [7:0]                             data_byte,
    output logic                                   wr_req,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]   wr_page,
    output logic [PAGE_BYTES-1:0]                  wr_be,
    output logic [PAGE_BYTES*8-1:0]                wr_data,
    output logic                                   busy,
    output logic [ADDR_W-1:0]                      ptr
);
    localparam int unsigned OFS_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              go;
    } eng_t;

    eng_t s_d, s_q;

    logic                  take_addr, take_data, stop_ok, launch;
    logic                  lat_clr;
    logic [PAGE_BYTES-1:0] lat_vld;

    always_comb begin
        s_d       = s_q;
        take_addr = addr_vld && !busy;
        take_data = data_vld && !busy && !addr_vld;
        stop_ok   = stop_evt && !busy && ((|lat_vld) || take_data);
        launch    = stop_ok && !wp_i;
        s_d.go    = launch;
        if (take_addr) begin
            s_d.ptr = {blk_sel, addr_byte};
        end else if (take_data) begin
            s_d.ptr[OFS_W-1:0] = s_q.ptr[OFS_W-1:0] + 1'b1;
        end
        lat_clr = s_q.go || (!busy && (start_evt || addr_vld)) || (stop_ok && wp_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    pw_latch #(.NBYTES(PAGE_BYTES)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (lat_clr),
        .we      (take_data),
        .ofs     (s_q.ptr[OFS_W-1:0]),
        .din     (data_byte),
        .valid_o (lat_vld),
        .data_o  (wr_data)
    );

    pw_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (busy)
    );

    assign wr_req  = s_q.go;
    assign wr_page = s_q.ptr[ADDR_W-1:OFS_W];
    assign wr_be   = lat_vld;
    assign ptr     = s_q.ptr;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req); // R5
    AST_REQ_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> busy); // R7
    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr)); // R7
    AST_WRAP_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld && !busy && !addr_vld) |=>
            (ptr[ADDR_W-1:OFS_W] == $past(ptr[ADDR_W-1:OFS_W]))); // R3
    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && wp_i && !busy) |=> !wr_req); // R8
    AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !busy && !data_vld && (wr_be == '0)) |=> !wr_req); // R6
endmodule

// File: tb/sim_pw_engine.sv
module sim_pw_engine;
    localparam int WC = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_evt = 0, stop_evt = 0, wp_i = 0, addr_vld = 0, data_vld = 0;
    logic [2:0]   blk_sel = '0;
    logic [7:0]   addr_byte = '0, data_byte = '0;
    logic         wr_req, busy;
    logic [6:0]   wr_page;
    logic [15:0]  wr_be;
    logic [127:0] wr_data;
    logic [10:0]  ptr;

    always #4 clk = ~clk;

    pw_engine #(.WRITE_CYCLES(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .wp_i(wp_i), .blk_sel(blk_sel), .addr_vld(addr_vld), .addr_byte(addr_byte),
        .data_vld(data_vld), .data_byte(data_byte), .wr_req(wr_req),
        .wr_page(wr_page), .wr_be(wr_be), .wr_data(wr_data), .busy(busy), .ptr(ptr)
    );

    int n_chk = 0, n_fail = 0, cyc_cnt = 0;
    string phase = "R1";

    // behavioural reference
    byte unsigned m_dat[16];
    bit           m_vld[16];
    int           m_ptr = 0, m_busy = 0;
    bit           m_go = 0;

    task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0; m_busy = 0; m_go = 0;
            foreach (m_vld[i]) m_vld[i] = 0;
        end else begin
            bit was_busy;
            bit any;
            was_busy = (m_busy > 0);
            if (m_go) begin
                foreach (m_vld[i]) m_vld[i] = 0;
                m_go = 0;
            end
            if (was_busy) m_busy--;
            else begin
                if (start_evt || addr_vld) foreach (m_vld[i]) m_vld[i] = 0;
                if (addr_vld) m_ptr = blk_sel * 256 + addr_byte;
                else if (data_vld) begin
                    m_dat[m_ptr % 16] = data_byte;
                    m_vld[m_ptr % 16] = 1;
                    m_ptr = (m_ptr / 16) * 16 + ((m_ptr % 16) + 1) % 16;
                end
                any = 0;
                foreach (m_vld[i]) any |= m_vld[i];
                if (stop_evt && any) begin
                    if (wp_i) foreach (m_vld[i]) m_vld[i] = 0;
                    else begin m_go = 1; m_busy = WC; end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] eb;
            foreach (m_vld[i]) eb[i] = m_vld[i];
            check(busy === (m_busy > 0), "R7", "busy", busy, m_busy > 0);
            check(ptr === 11'(m_ptr), phase, "ptr", ptr, m_ptr);
            check(wr_req === m_go, phase, "wr_req", wr_req, m_go);
            if (m_go) begin
                check(wr_be === eb, phase, "wr_be", wr_be, eb);
                check(wr_page === 7'(m_ptr / 16), "R5", "wr_page", wr_page, m_ptr / 16);
                for (int i = 0; i < 16; i++)
                    if (m_vld[i])
                        check(wr_data[i*8 +: 8] === m_dat[i], phase, "wr_data byte",
                              wr_data[i*8 +: 8], m_dat[i]);
            end
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
        start_evt = 0; stop_evt = 0; addr_vld = 0; data_vld = 0;
    endtask
    task automatic send_addr(input logic [2:0] b, input logic [7:0] a);
        start_evt = 1; cyc();
        blk_sel = b; addr_byte = a; addr_vld = 1; cyc();
    endtask
    task automatic send_data(input logic [7:0] d);
        data_byte = d; data_vld = 1; cyc();
    endtask
    task automatic send_stop();
        stop_evt = 1; cyc();
    endtask
    task automatic settle();
        repeat (WC + 3) cyc();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 50000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<50000", cyc_cnt);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check(busy === 1'b0, "R1", "busy", busy, 0);
        check(wr_req === 1'b0, "R1", "wr_req", wr_req, 0);
        check(ptr === 11'd0, "R1", "ptr", ptr, 0);
        rst_n = 1; cyc();

        phase = "R2"; send_addr(3'd3, 8'h45);
        phase = "R5"; send_data(8'hA1); send_stop(); settle();

        phase = "R3"; send_addr(3'd5, 8'h0E);
        for (int i = 0; i < 4; i++) send_data(8'h10 + 8'(i));
        phase = "R11"; send_stop(); settle();

        phase = "R4"; send_addr(3'd1, 8'h20);
        for (int i = 0; i < 18; i++) send_data(8'h40 + 8'(i));
        send_stop(); settle();

        phase = "R6"; start_evt = 1; cyc(); send_stop(); settle();

        phase = "R7"; send_addr(3'd2, 8'h77); send_data(8'h5A); send_stop();
        repeat (3) cyc();
        send_addr(3'd6, 8'h11); send_data(8'hEE); send_stop();
        settle();

        phase = "R8"; wp_i = 1; send_addr(3'd7, 8'h03);
        send_data(8'hC3); send_data(8'hC4); send_stop();
        wp_i = 0; cyc(); send_stop(); settle();

        phase = "R9"; send_addr(3'd4, 8'h90); send_data(8'h01); send_data(8'h02);
        start_evt = 1; cyc(); send_stop(); cyc();
        send_data(8'h33); send_stop(); settle();

        phase = "R10"; send_addr(3'd0, 8'hF7); send_data(8'h61);
        data_byte = 8'h62; data_vld = 1; stop_evt = 1; cyc(); settle();

        finish_run();
    end
endmodule